// File: doc/BRIEF.md
# Interrupt Command and Pending-Vector Unit

This block is the register slice of a per-processor interrupt controller that turns software-issued interrupts into pending vectors. It decodes word writes from a memory-mapped bus. The decoded registers are a task priority register, an end-of-interrupt register, a fixed version register and a command register that spans two words. A write to the low command word can post an interrupt vector into a 256-entry pending bitmap. Other local interrupt sources, such as a timer or an I/O interrupt router, post into the same bitmap through a set of request inputs.

The processor side sees one pending vector at a time. The block shows the highest-numbered pending vector together with a valid flag. An acknowledge pulse clears that vector's bit in the bitmap. Reads on the bus use the current address and return data in the same cycle. Writes take effect at the clock edge. Sending messages to other processors and blocking by task priority are outside this block.

Top module: `icpv_unit`

## Requirements
- R1: A read of offset 0x030 returns the constant 0x00050011.
- R2: Offset 0x080 holds a 32-bit priority word. A write stores the full value, a read returns it, and it holds its value while no write targets it.
- R3: A write to offset 0x0B0 (end of interrupt) changes no register and no pending bit, and a read of 0x0B0 returns 0.
- R4: Offset 0x310 holds the high command word. The destination field sits in bits 31:24. The full written word reads back, and the write posts nothing.
- R5: A write to offset 0x300 stores the low command word, which reads back in full. If the delivery mode field (bits 10:8) is 0 or 1 and bit 16 is clear, the vector in bits 7:0 becomes pending from the next cycle.
- R6: A write to 0x300 whose delivery mode is 2 to 7, or whose bit 16 is set, only stores the word and posts no vector.
- R7: Every request input whose valid bit is high in a cycle posts its 8-bit vector from the next cycle, and several inputs may post in the same cycle.
- R8: irq_valid is high exactly when at least one vector is pending.
- R9: When irq_valid is high, irq_vector is the highest-numbered pending vector. This covers vector 0 and vector 255.
- R10: If irq_ack is high at a clock edge while irq_valid is high, the presented vector's bit is cleared at that edge. If irq_ack is high while irq_valid is low, it has no effect.
- R11: If a post and an acknowledge of the same vector happen in the same cycle, the bit stays set.
- R12: A read of any other offset returns 0. A write to any other offset changes no register and no pending bit.
- R13: An asynchronous active-low reset clears the priority word, both command words and the whole pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_valid | input | NUM_SRC (2) | Per-source post request |
| src_vector | input | 8*NUM_SRC (16) | Vector of each source, source s in bits 8s+7:8s |
| irq_valid | output | 1 | At least one vector pending |
| irq_vector | output | 8 | Highest pending vector |
| irq_ack | input | 1 | Take the presented vector and clear its bit |

## Verification
The pending bitmap is only visible through the highest-vector output. A bit that is wrongly set or wrongly lost therefore shows up at the ports only when every vector above it has been acknowledged. Until then it is hidden. For this reason the bench drains the bitmap completely after each posting pattern, so every stored bit is presented and compared within a few cycles. A wrong register value shows on bus_rdata in the same cycle the offset is addressed, because reads are combinational.

// File: rtl/icpv_pkg.sv
package icpv_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int VEC_W    = 8;
    localparam int NUM_VEC  = 1 << VEC_W;

    localparam logic [ADDR_W-1:0] OFF_VER    = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_TPR    = 12'h080;
    localparam logic [ADDR_W-1:0] OFF_EOI    = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFF_ICR_LO = 12'h300;
    localparam logic [ADDR_W-1:0] OFF_ICR_HI = 12'h310;

    localparam logic [DATA_W-1:0] VERSION_WORD = 32'h0005_0011;

    // low command word field positions
    localparam int MODE_LSB = 8;
    localparam int MODE_W   = 3;
    localparam int MASK_BIT = 16;

    typedef struct packed {
        logic [DATA_W-1:0] prio;
        logic [DATA_W-1:0] cmd_lo;
        logic [DATA_W-1:0] cmd_hi;
    } cmd_regs_t;
endpackage

// File: rtl/icpv_cmd_regs.sv
module icpv_cmd_regs
    import icpv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              post_valid,
    output logic [VEC_W-1:0]  post_vector
);
    cmd_regs_t regs_d, regs_q;
    logic [MODE_W-1:0] mode_w;

    assign mode_w = bus_wdata[MODE_LSB +: MODE_W];

    always_comb begin
        regs_d      = regs_q;
        post_valid  = 1'b0;
        post_vector = bus_wdata[VEC_W-1:0];
        if (bus_wr) begin
            case (bus_addr)
                OFF_TPR:    regs_d.prio   = bus_wdata;
                OFF_ICR_HI: regs_d.cmd_hi = bus_wdata;
                OFF_ICR_LO: begin
                    regs_d.cmd_lo = bus_wdata;
                    // fixed and lowest-priority modes deliver locally
                    post_valid = (mode_w <= MODE_W'(1)) && !bus_wdata[MASK_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            OFF_VER:    bus_rdata = VERSION_WORD;
            OFF_TPR:    bus_rdata = regs_q.prio;
            OFF_ICR_LO: bus_rdata = regs_q.cmd_lo;
            OFF_ICR_HI: bus_rdata = regs_q.cmd_hi;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/icpv_pend_set.sv
module icpv_pend_set
    import icpv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] post_mask,
    input  logic               clr_valid,
    input  logic [VEC_W-1:0]   clr_vector,
    output logic [NUM_VEC-1:0] pend_q
);
    logic [NUM_VEC-1:0] pend_d;
    logic [NUM_VEC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_valid) clr_mask[clr_vector] = 1'b1;
        // a post in the same cycle overrides the clear
        pend_d = (pend_q & ~clr_mask) | post_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/icpv_top_pick.sv
module icpv_top_pick
    import icpv_pkg::*;
(
    input  logic [NUM_VEC-1:0] pend,
    output logic               any,
    output logic [VEC_W-1:0]   top
);
    always_comb begin
        any = |pend;
        top = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (pend[i]) top = VEC_W'(i);
        end
    end
endmodule

// File: rtl/icpv_unit.sv
module icpv_unit
    import icpv_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_SRC-1:0]       src_valid,
    input  logic [VEC_W*NUM_SRC-1:0] src_vector,
    output logic                     irq_valid,
    output logic [VEC_W-1:0]         irq_vector,
    input  logic                     irq_ack
);
    logic               cmd_post;
    logic [VEC_W-1:0]   cmd_vec;
    logic [NUM_VEC-1:0] post_mask;
    logic [NUM_VEC-1:0] src_mask [NUM_SRC];
    logic [NUM_VEC-1:0] pend;

    icpv_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .post_valid (cmd_post),
        .post_vector(cmd_vec)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_comb begin
            src_mask[s] = '0;
            if (src_valid[s]) src_mask[s][src_vector[s*VEC_W +: VEC_W]] = 1'b1;
        end
    end

    always_comb begin
        post_mask = '0;
        if (cmd_post) post_mask[cmd_vec] = 1'b1;
        for (int s = 0; s < NUM_SRC; s++) post_mask = post_mask | src_mask[s];
    end

    icpv_pend_set u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_mask (post_mask),
        .clr_valid (irq_ack && irq_valid),
        .clr_vector(irq_vector),
        .pend_q    (pend)
    );

    icpv_top_pick u_pick (
        .pend(pend),
        .any (irq_valid),
        .top (irq_vector)
    );
endmodule

// File: rtl/icpv_unit_chk.sv
module icpv_unit_chk
    import icpv_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [NUM_SRC-1:0]       src_valid,
    input logic                     irq_valid,
    input logic [VEC_W-1:0]         irq_vector,
    input logic                     irq_ack
);
    logic no_post;
    assign no_post = !bus_wr && (src_valid == '0);

    AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_VER) |-> (bus_rdata == VERSION_WORD)); // R1
    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_TPR && !bus_wr) |=> (bus_addr != OFF_TPR || $stable(bus_rdata))); // R2
    AST_CMD_POST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ICR_LO && bus_wdata[10:9] == 2'b00 && !bus_wdata[MASK_BIT])
        |=> (irq_valid && irq_vector >= $past(bus_wdata[VEC_W-1:0]))); // R5
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid && no_post) |=> !irq_valid); // R8
    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> irq_valid); // R8
    AST_TOP_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_vector >= $past(irq_vector))); // R9
    AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && no_post)
        |=> (!irq_valid || irq_vector < $past(irq_vector))); // R10
endmodule

bind icpv_unit icpv_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_valid (src_valid),
    .irq_valid (irq_valid),
    .irq_vector(irq_vector),
    .irq_ack   (irq_ack)
);

// File: tb/icpv_unit_bench.sv
module icpv_unit_bench;
    localparam int NSRC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0]   src_valid = '0;
    logic [8*NSRC-1:0] src_vector = '0;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    icpv_unit #(.NUM_SRC(NSRC)) u_icpv_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
        .src_vector(src_vector), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .irq_ack(irq_ack)
    );

    // ---------------- behavioural reference ----------------
    bit          m_pend [256];
    logic [31:0] m_prio, m_lo, m_hi;

    function automatic int m_top();
        for (int i = 255; i >= 0; i--) if (m_pend[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        case (a)
            12'h030: return 32'h0005_0011;
            12'h080: return m_prio;
            12'h300: return m_lo;
            12'h310: return m_hi;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(logic [11:0] a);
        case (a)
            12'h030: return "R1";
            12'h080: return "R2";
            12'h0B0: return "R3";
            12'h300: return "R5";
            12'h310: return "R4";
            default: return "R12";
        endcase
    endfunction

    int t_now;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 1'b0;
            m_prio = '0; m_lo = '0; m_hi = '0;
        end else begin
            t_now = m_top();
            if (irq_ack && t_now >= 0) m_pend[t_now] = 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    12'h080: m_prio = bus_wdata;
                    12'h310: m_hi = bus_wdata;
                    12'h300: begin
                        m_lo = bus_wdata;
                        if (bus_wdata[10:8] <= 3'd1 && !bus_wdata[16]) m_pend[bus_wdata[7:0]] = 1'b1;
                    end
                    default: ;
                endcase
            end
            for (int s = 0; s < NSRC; s++)
                if (src_valid[s]) m_pend[src_vector[8*s +: 8]] = 1'b1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        int t;
        t = m_top();
        chk("R8", {31'b0, irq_valid}, {31'b0, t >= 0});
        if (t >= 0) chk("R9", {24'b0, irq_vector}, t[31:0]);
        chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic drain();
        while (irq_valid) ack_once();
        step();
    endtask

    initial begin
        step(); step();
        // R13: reset state
        bus_addr = 12'h080; #0.1;
        chk("R13", {31'b0, irq_valid}, 32'd0);
        chk("R13", bus_rdata, 32'd0);
        rst_n = 1'b1; step();

        bus_addr = 12'h030; step();                        // R1
        wr(12'h080, 32'hDEAD_BEEF); step();                // R2
        chk("R2", bus_rdata, 32'hDEAD_BEEF);
        wr(12'h310, 32'hAB00_1234); step();                // R4
        chk("R4", {31'b0, irq_valid}, 32'd0);
        wr(12'h300, 32'h0000_0042);                        // R5 mode 0
        wr(12'h300, 32'h0000_0155);                        // R5 mode 1
        chk("R5", {24'b0, irq_vector}, 32'h55);
        wr(12'h300, 32'h0000_0290);                        // R6 mode 2
        wr(12'h300, 32'h0000_07E0);                        // R6 mode 7
        wr(12'h300, 32'h0001_00A0);                        // R6 masked
        step();
        chk("R6", {24'b0, irq_vector}, 32'h55);
        chk("R6", bus_rdata, 32'h0001_00A0);
        wr(12'h0B0, 32'hFFFF_FFFF); step();                // R3
        chk("R3", {24'b0, irq_vector}, 32'h55);
        wr(12'h3E0, 32'h0000_0005);                        // R12
        wr(12'h084, 32'h1111_1111);
        bus_addr = 12'h080; step();
        chk("R12", bus_rdata, 32'hDEAD_BEEF);

        // R7: two sources in one cycle
        src_valid = 2'b11; src_vector = {8'hF0, 8'h10}; step();
        src_valid = 2'b00; step();
        chk("R7", {24'b0, irq_vector}, 32'hF0);
        src_valid = 2'b11; src_vector = {8'h33, 8'h33}; step();
        src_valid = 2'b00; step();

        // R10: drain in descending order, then ack while empty
        drain();
        chk("R10", {31'b0, irq_valid}, 32'd0);
        ack_once(); ack_once(); step();
        chk("R10", {31'b0, irq_valid}, 32'd0);

        // R11: post and ack of the same vector together
        src_valid = 2'b01; src_vector = 16'h0077; step();
        irq_ack = 1'b1; step();
        irq_ack = 1'b0; src_valid = 2'b00; step();
        chk("R11", {31'b0, irq_valid}, 32'd1);
        chk("R11", {24'b0, irq_vector}, 32'h77);
        drain();

        // R9: boundary vectors 0 and 255
        wr(12'h300, 32'h0000_0000);
        chk("R9", {24'b0, irq_vector}, 32'h00);
        wr(12'h300, 32'h0000_00FF);
        chk("R9", {24'b0, irq_vector}, 32'hFF);
        drain();

        // R13: reset in mid-run
        wr(12'h300, 32'h0000_0061);
        bus_addr = 12'h300;
        rst_n = 1'b0; step();
        chk("R13", {31'b0, irq_valid}, 32'd0);
        chk("R13", bus_rdata, 32'd0);
        rst_n = 1'b1; step(); step();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule